// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block produces the clock that drives a memory-card bus. The clock is divided down from the block's reference clock `clk` by a power of two chosen by software. `clk` runs at twice the nominal source rate, so divider value D gives a card clock of source / 2^D. D = 0 passes the source rate through, and D = 7 gives the slowest rate, source / 128. Software normally picks the smallest D whose resulting rate does not exceed the rate it wants.

The clock is switched on and off through one-shot request bits in a control register. Software then polls a status flag to learn when the clock has actually started or stopped. The clock is only switched, and a new divider only loaded, at the end of a low phase of the card clock. As a result, every high pulse that leaves the block has its full length.

The same control register carries two further strobes. One is an operation-start strobe, which sends a one-cycle pulse to the command engine. The other is a controller-reset request, which sets a busy status bit for a short fixed time.

Top module: `card_clk_gen`

## Requirements
- R1: While the clock is running, each high phase and each low phase of `card_clk` lasts exactly 2^D cycles of `clk`. D is the active divider value.
- R2: The divider register is at address 2 and holds D in bits [2:0]. It reads back the last value written, and bits [15:3] read as 0.
- R3: A newly written divider value takes effect only at the end of a low phase. Every high pulse on `card_clk` lasts 2^k cycles for some k from 0 to 7, so no shortened pulse appears.
- R4: The control register is at address 0. Writing 1 to bit 0 requests a stop, and writing 1 to bit 1 requests a start. The clock switches on or off only at the end of a low phase, and `card_clk` stays 0 while the clock is stopped.
- R5: The status register is at address 1. Its bit 8 reads 1 exactly while the clock is running. The bit becomes 1 within 256 cycles after a start request and 0 within 256 cycles after a stop request.
- R6: If a single control write sets both bit 0 and bit 1, the stop request takes effect and the clock ends up stopped.
- R7: Writing 1 to control bit 2 raises `start_op` for exactly one `clk` cycle: the cycle after the write. This also applies when bit 2 is written together with bit 1. No other write raises `start_op`.
- R8: Writing 1 to control bit 3 sets status bit 15 for exactly 4 cycles, starting the cycle after the write, after which the bit clears by itself. A further reset request made while status bit 15 is 1 is ignored.
- R9: The control register always reads as 0, and writing 0 to a control bit has no effect. A control write of all zeros leaves a running clock running.
- R10: After reset, `card_clk` is 0, `start_op` is 0, status reads 0, and the divider reads 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, twice the nominal source rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| card_clk | output | 1 | Gated, divided card clock |
| start_op | output | 1 | One-cycle operation-start pulse to the command engine |

## Verification
The hardest case to reach is a divider change or a stop request that lands in the middle of a high phase, or just before a low-phase boundary, at a slow divider. Only then would a wrong design cut a pulse short. The random stimulus writes new divider values and stop or start requests at random offsets while the clock runs. The bench measures the length of every high pulse seen on `card_clk` and checks each one against the set of legal lengths.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int DATA_W = 16;
  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_STATUS = 2'd1;
  localparam logic [1:0] A_DIV    = 2'd2;
  localparam int CT_STOP   = 0;
  localparam int CT_START  = 1;
  localparam int CT_OP     = 2;
  localparam int CT_RESET  = 3;
  localparam int ST_CLK_ON = 8;
  localparam int ST_RST    = 15;

  // number of reference cycles in one half period for divider code d
  function automatic int unsigned half_cycles(input int unsigned d);
    return 32'd1 << d;
  endfunction
endpackage

// File: rtl/ckdiv_prescaler.sv
module ckdiv_prescaler #(
  parameter int DIV_W = 3,
  localparam int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  import ckdiv_pkg::*;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'(half_cycles(32'(div)) - 1);
    tick = (cnt == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ckdiv_gate.sv
module ckdiv_gate #(
  parameter int DIV_W = 3,
  parameter logic [DIV_W-1:0] DIV_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_req,
  input  logic [DIV_W-1:0] div_req,
  output logic             card_clk,
  output logic             running,
  output logic [DIV_W-1:0] active_div
);
  logic low_edge;
  assign low_edge = tick && !card_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_clk   <= 1'b0;
      running    <= 1'b0;
      active_div <= DIV_RST;
    end else if (tick) begin
      if (card_clk) begin
        card_clk <= 1'b0;
      end else begin
        running    <= run_req;
        active_div <= div_req;
        card_clk   <= run_req;
      end
    end
  end

  logic unused_low_edge;
  assign unused_low_edge = low_edge;
endmodule

// File: rtl/ckdiv_regs.sv
module ckdiv_regs #(
  parameter int DIV_W = 3,
  parameter logic [DIV_W-1:0] DIV_RST = '1,
  parameter int RST_CYCLES = 4,
  localparam int RC_W = $clog2(RST_CYCLES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [1:0]                   reg_addr,
  input  logic [ckdiv_pkg::DATA_W-1:0] reg_wdata,
  input  logic                         running,
  output logic [ckdiv_pkg::DATA_W-1:0] reg_rdata,
  output logic                         run_req,
  output logic [DIV_W-1:0]             div_reg,
  output logic                         start_op,
  output logic                         rst_busy
);
  import ckdiv_pkg::*;
  logic          wr_ctrl, wr_div;
  logic [RC_W-1:0] rst_cnt;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_div   = reg_wr && (reg_addr == A_DIV);
  assign rst_busy = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req  <= 1'b0;
      div_reg  <= DIV_RST;
      start_op <= 1'b0;
      rst_cnt  <= '0;
    end else begin
      start_op <= wr_ctrl && reg_wdata[CT_OP];
      if (wr_ctrl && reg_wdata[CT_STOP])       run_req <= 1'b0;
      else if (wr_ctrl && reg_wdata[CT_START]) run_req <= 1'b1;
      if (wr_div) div_reg <= reg_wdata[DIV_W-1:0];
      if (wr_ctrl && reg_wdata[CT_RESET] && !rst_busy) rst_cnt <= RC_W'(RST_CYCLES);
      else if (rst_busy)                              rst_cnt <= rst_cnt - 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: begin
        reg_rdata[ST_CLK_ON] = running;
        reg_rdata[ST_RST]    = rst_busy;
      end
      A_DIV:   reg_rdata[DIV_W-1:0] = div_reg;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int DIV_W = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        card_clk,
  output logic        start_op
);
  localparam logic [DIV_W-1:0] DIV_RST = '1;

  logic             tick;
  logic             run_req;
  logic             running;
  logic             rst_busy;
  logic [DIV_W-1:0] div_reg;
  logic [DIV_W-1:0] active_div;

  ckdiv_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .running(running), .reg_rdata(reg_rdata),
    .run_req(run_req), .div_reg(div_reg), .start_op(start_op), .rst_busy(rst_busy)
  );

  ckdiv_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div(active_div), .tick(tick)
  );

  ckdiv_gate #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_req(run_req), .div_req(div_reg),
    .card_clk(card_clk), .running(running), .active_div(active_div)
  );
endmodule

// File: rtl/ckdiv_checker.sv
module ckdiv_checker #(
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [15:0]      reg_wdata,
  input logic [15:0]      reg_rdata,
  input logic             card_clk,
  input logic             start_op,
  input logic             run_req,
  input logic             running,
  input logic [DIV_W-1:0] active_div,
  input logic             rst_busy
);
  logic wr_ctrl;
  assign wr_ctrl = reg_wr && (reg_addr == 2'd0);

  AST_GATE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (running != $past(running)) |-> !$past(card_clk)); // R4
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !card_clk); // R4
  AST_DIV_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (active_div != $past(active_div)) |-> !$past(card_clk)); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[0] && reg_wdata[1]) |=> !run_req); // R6
  AST_OP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |-> $past(wr_ctrl && reg_wdata[2])); // R7
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_busy) |=> rst_busy ##1 rst_busy ##1 rst_busy ##1 !rst_busy); // R8
  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata == 16'h0)); // R9
  AST_DIV_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[15:DIV_W] == '0)); // R2
endmodule

bind card_clk_gen ckdiv_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_clk(card_clk),
  .start_op(start_op), .run_req(run_req), .running(running),
  .active_div(active_div), .rst_busy(rst_busy)
);

// File: tb/card_clk_gen_test.sv
`timescale 1ns/1ps
module card_clk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        card_clk;
  logic        start_op;

  int checks = 0;
  int fails = 0;
  int mon_bad = 0;
  int mon_pulses = 0;
  int hi_run = 0;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  card_clk_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_clk(card_clk), .start_op(start_op)
  );

  function automatic int exp_half(input int d);
    int v = 1;
    for (int i = 0; i < d; i++) v = v * 2;
    return v;
  endfunction

  function automatic bit legal_len(input int n);
    for (int k = 0; k < 8; k++) if (n == exp_half(k)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 16'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // R3: every high pulse must have a legal full length
  always @(negedge clk) begin
    if (mon_on) begin
      if (card_clk) hi_run++;
      else if (hi_run != 0) begin
        mon_pulses++;
        if (!legal_len(hi_run)) mon_bad++;
        hi_run = 0;
      end
    end
  end

  task automatic wait_status(input bit want, output int waited);
    logic [15:0] s;
    waited = 0;
    rd(2'd1, s);
    while (s[8] != want && waited < 400) begin
      @(negedge clk); waited++;
      rd(2'd1, s);
    end
  endtask

  task automatic measure(output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (card_clk && guard < 400) begin @(negedge clk); guard++; end
    while (!card_clk && guard < 800) begin @(negedge clk); guard++; end
    while (card_clk && guard < 1200) begin hi++; @(negedge clk); guard++; end
    while (!card_clk && guard < 1600) begin lo++; @(negedge clk); guard++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    int hi, lo, w, cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 card_clk", card_clk, 0);
    check("R10 start_op", start_op, 0);
    rd(2'd1, r); check("R10 status", r, 0);
    rd(2'd2, r); check("R10 divider", r, 7);
    rd(2'd0, r); check("R9 ctrl reads 0", r, 0);
    mon_on = 1'b1;

    // R2 divider readback
    wr(2'd2, 16'hFFF2); rd(2'd2, r); check("R2 readback", r, 2);

    // R7 + R4 + R5: start with op strobe
    wr(2'd0, 16'h0006);
    check("R7 start_op pulse", start_op, 1);
    @(negedge clk); check("R7 start_op one cycle", start_op, 0);
    wait_status(1'b1, w); check("R5 running set", (w < 256) ? 1 : 0, 1);
    measure(hi, lo); check("R1 high d=2", hi, 4); check("R1 low d=2", lo, 4);

    // R9 zero write keeps running, no start_op
    wr(2'd0, 16'h0000);
    check("R7 no pulse on zero write", start_op, 0);
    repeat (20) @(negedge clk);
    rd(2'd1, r); check("R9 still running", r[8], 1);
    rd(2'd0, r); check("R9 ctrl reads 0 after write", r, 0);

    // directed d=0 and d=7
    wr(2'd2, 16'h0000); measure(hi, lo); measure(hi, lo);
    check("R1 high d=0", hi, 1); check("R1 low d=0", lo, 1);
    wr(2'd2, 16'h0007); measure(hi, lo); measure(hi, lo);
    check("R1 high d=7", hi, 128); check("R1 low d=7", lo, 128);

    // R4 R5 stop, clock stays low
    wr(2'd0, 16'h0001);
    wait_status(1'b0, w); check("R5 stop seen", (w < 256) ? 1 : 0, 1);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (card_clk) cnt++; end
    check("R4 low while stopped", cnt, 0);

    // R6 stop wins
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0003);
    repeat (300) @(negedge clk);
    rd(2'd1, r); check("R6 stop wins", r[8], 0);

    // R8 reset busy, retrigger ignored
    wr(2'd0, 16'h0008);
    cnt = 1;
    rd(2'd1, r); check("R8 busy set", r[15], 1);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0008;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 16'h0;
    rd(2'd1, r);
    while (r[15] && cnt < 20) begin cnt++; @(negedge clk); rd(2'd1, r); end
    check("R8 busy length", cnt, 4);

    // random mix of divider changes and gating
    wr(2'd0, 16'h0002);
    for (int it = 0; it < 40; it++) begin
      int d = $urandom_range(0, 5);
      int gap = $urandom_range(0, 40);
      repeat (gap) @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin
        wr(2'd0, 16'h0001);
        repeat ($urandom_range(0, 70)) @(negedge clk);
        wr(2'd0, 16'h0002);
      end
      wr(2'd2, 16'(d));
      rd(2'd2, r); check("R2 random readback", r, d);
      measure(hi, lo);
      measure(hi, lo);
      check("R1 random high", hi, exp_half(d));
      check("R1 random low", lo, exp_half(d));
    end

    mon_on = 1'b0;
    check("R3 all pulses full length", mon_bad, 0);
    check("R3 pulses seen", (mon_pulses > 50) ? 1 : 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule